// File: doc/BRIEF.md
# Gshare Branch Predictor with Selective Target-Buffer Reads

This block is the fetch-stage direction and target predictor. A 2-bit counter table is indexed by the fetch address XORed with a global history of resolved outcomes. A direct-mapped target buffer supplies the taken target. Each fetch cycle the block returns a taken/not-taken guess and a next-fetch address, both combinational from the current fetch address and the registered state.

The block cuts the number of counter-table and target-buffer reads without changing any prediction. Counters are stored two to a row, so one row read serves two neighbouring indices. The row last read is remembered, and a fetch that falls in that row needs no new read. When such a fetch follows an instruction that was not a branch, its direction is already known from the earlier read. If that direction is not-taken, the target buffer is not read in that cycle, because the fall-through address needs no target. A branch resolving on the update port trains the counter, shifts the history and, when taken, writes the target buffer. Two free-running counters record the cycles in which each structure was read, so the saving can be measured.

Top module: `gshare_gated_bp`

## Requirements
- R1: The counter index is fetch_pc[IDX_W+1:2] XOR the history register. Every counter resets to 1. A fetch is predicted taken exactly when fetch_valid is high and its counter is 2 or 3.
- R2: An update moves the counter at upd_pc[IDX_W+1:2] XOR history (history as it was before the update) up by one on taken and down by one on not-taken, saturating at 0 and 3.
- R3: The history register resets to zero. Each update shifts it left by one, and the resolved outcome enters bit 0.
- R4: Counters pair up into rows by index bit 0, so the row is index[IDX_W-1:1]. pht_en is high for a valid fetch unless its row is the one held from an earlier read with no update since.
- R5: An update clears the held row, so the next valid fetch asserts pht_en.
- R6: btb_en is low for a valid fetch that is predicted not-taken and uses the held row, when the most recent earlier valid fetch was neither predicted taken nor hit in the target buffer.
- R7: In every other valid fetch cycle btb_en is high. When fetch_valid is low, pht_en, btb_en and pred_taken are all low.
- R8: The target buffer has 2**BTB_IDX_W entries, indexed by pc[BTB_IDX_W+1:2] and tagged with pc[PC_W-1:BTB_IDX_W+2]. A taken update writes the entry. pred_target is the stored target when the fetch is predicted taken and hits; otherwise it is fetch_pc+4.
- R9: pht_cnt and btb_cnt reset to zero and rise by one after every cycle in which pht_en or btb_en, respectively, was high.
- R10: pred_taken and pred_target equal those of the same predictor reading both tables every cycle.
- R11: A fetch and an update in the same cycle: the fetch sees the state from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A fetch address is presented this cycle |
| fetch_pc | input | PC_W | Fetch address (byte address, 4-byte instructions) |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | PC_W | Resolved target |
| pred_taken | output | 1 | Predicted direction for fetch_pc |
| pred_target | output | PC_W | Predicted next fetch address |
| pht_en | output | 1 | Counter-table row read this cycle |
| btb_en | output | 1 | Target buffer read this cycle |
| pht_cnt | output | CNT_W | Cycles with pht_en high |
| btb_cnt | output | CNT_W | Cycles with btb_en high |

## Verification
A held row that survives an update would show up in the first fetch after that update. pht_en would stay low there, and a stale direction could appear in the same cycle. A wrong branch-flag state shows at once as a btb_en that differs from the reference. If it let the buffer be skipped on a taken fetch, pred_target would fall through to pc+4 in that same cycle. A wrong history or counter step shows up only once the affected index is fetched again, so the bench trains one index to saturation and then probes it.

// File: rtl/gbp_pkg.sv
package gbp_pkg;

    localparam logic [1:0] CTR_RESET = 2'd1;

    // saturating 2-bit step
    function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
        logic [1:0] r;
        r = c;
        if (up && c != 2'd3)
            r = c + 2'd1;
        else if (!up && c != 2'd0)
            r = c - 2'd1;
        return r;
    endfunction

endpackage

// File: rtl/gbp_pht.sv
module gbp_pht #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up,
    output logic [1:0]       rd_ctr
);
    import gbp_pkg::*;

    localparam int ROWS = 1 << (IDX_W - 1);

    logic [1:0] row_q [ROWS][2];
    logic [1:0] row_d [ROWS][2];

    always_comb begin
        row_d = row_q;
        if (wr_en)
            row_d[wr_idx[IDX_W-1:1]][wr_idx[0]] =
                ctr_step(row_q[wr_idx[IDX_W-1:1]][wr_idx[0]], wr_up);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                row_q[r][0] <= CTR_RESET;
                row_q[r][1] <= CTR_RESET;
            end
        end else begin
            row_q <= row_d;
        end
    end

    assign rd_ctr = row_q[rd_idx[IDX_W-1:1]][rd_idx[0]];

endmodule

// File: rtl/gbp_btb.sv
module gbp_btb #(
    parameter int PC_W     = 16,
    parameter int BTB_IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_en,
    input  logic [PC_W-1:0] rd_pc,
    input  logic            wr_en,
    input  logic [PC_W-1:0] wr_pc,
    input  logic [PC_W-1:0] wr_target,
    output logic            rd_hit,
    output logic [PC_W-1:0] rd_target
);
    localparam int ENTRIES = 1 << BTB_IDX_W;
    localparam int TAG_W   = PC_W - 2 - BTB_IDX_W;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [PC_W-1:0]  tgt;
    } ent_t;

    ent_t ent_q [ENTRIES];
    ent_t ent_d [ENTRIES];

    logic [BTB_IDX_W-1:0] rd_slot, wr_slot;
    assign rd_slot = rd_pc[BTB_IDX_W+1:2];
    assign wr_slot = wr_pc[BTB_IDX_W+1:2];

    always_comb begin
        ent_d = ent_q;
        if (wr_en)
            ent_d[wr_slot] = '{vld: 1'b1, tag: wr_pc[PC_W-1:BTB_IDX_W+2], tgt: wr_target};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++)
                ent_q[e] <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

    assign rd_hit    = rd_en && ent_q[rd_slot].vld &&
                       (ent_q[rd_slot].tag == rd_pc[PC_W-1:BTB_IDX_W+2]);
    assign rd_target = ent_q[rd_slot].tgt;

endmodule

// File: rtl/gbp_ctl.sv
module gbp_ctl #(
    parameter int IDX_W = 6,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_valid,
    input  logic [IDX_W-1:0] fetch_idx,
    input  logic             dir_taken,
    input  logic             tgt_hit,
    input  logic             upd_valid,
    output logic             pht_en,
    output logic             btb_en,
    output logic [CNT_W-1:0] pht_cnt,
    output logic [CNT_W-1:0] btb_cnt
);
    localparam int ROW_W = IDX_W - 1;

    typedef struct packed {
        logic             held_vld;
        logic [ROW_W-1:0] held_row;
        logic             prev_br;
        logic [CNT_W-1:0] pcnt;
        logic [CNT_W-1:0] bcnt;
    } st_t;

    st_t st_q, st_d;

    logic row_hit, early;
    assign row_hit = st_q.held_vld && (st_q.held_row == fetch_idx[IDX_W-1:1]);
    assign early   = row_hit && !st_q.prev_br;
    assign pht_en  = fetch_valid && !row_hit;
    assign btb_en  = fetch_valid && (!early || dir_taken);

    always_comb begin
        st_d = st_q;
        if (upd_valid) begin
            st_d.held_vld = 1'b0;
        end else if (pht_en) begin
            st_d.held_vld = 1'b1;
            st_d.held_row = fetch_idx[IDX_W-1:1];
        end
        if (fetch_valid)
            st_d.prev_br = dir_taken || tgt_hit;
        st_d.pcnt = st_q.pcnt + CNT_W'(pht_en);
        st_d.bcnt = st_q.bcnt + CNT_W'(btb_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign pht_cnt = st_q.pcnt;
    assign btb_cnt = st_q.bcnt;

endmodule

// File: rtl/gshare_gated_bp.sv
module gshare_gated_bp #(
    parameter int PC_W      = 16,
    parameter int IDX_W     = 6,
    parameter int BTB_IDX_W = 4,
    parameter int CNT_W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_valid,
    input  logic [PC_W-1:0]  fetch_pc,
    input  logic             upd_valid,
    input  logic [PC_W-1:0]  upd_pc,
    input  logic             upd_taken,
    input  logic [PC_W-1:0]  upd_target,
    output logic             pred_taken,
    output logic [PC_W-1:0]  pred_target,
    output logic             pht_en,
    output logic             btb_en,
    output logic [CNT_W-1:0] pht_cnt,
    output logic [CNT_W-1:0] btb_cnt
);
    localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

    logic [IDX_W-1:0] ghr_q, ghr_d;
    logic [IDX_W-1:0] f_idx, u_idx;
    logic [1:0]       f_ctr;
    logic             t_hit;
    logic [PC_W-1:0]  t_tgt;

    assign f_idx = fetch_pc[IDX_W+1:2] ^ ghr_q;
    assign u_idx = upd_pc[IDX_W+1:2] ^ ghr_q;

    always_comb begin
        ghr_d = ghr_q;
        if (upd_valid)
            ghr_d = {ghr_q[IDX_W-2:0], upd_taken};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ghr_q <= '0;
        else
            ghr_q <= ghr_d;
    end

    gbp_pht #(.IDX_W(IDX_W)) u_pht (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (f_idx),
        .wr_en  (upd_valid),
        .wr_idx (u_idx),
        .wr_up  (upd_taken),
        .rd_ctr (f_ctr)
    );

    gbp_btb #(.PC_W(PC_W), .BTB_IDX_W(BTB_IDX_W)) u_btb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (btb_en),
        .rd_pc     (fetch_pc),
        .wr_en     (upd_valid && upd_taken),
        .wr_pc     (upd_pc),
        .wr_target (upd_target),
        .rd_hit    (t_hit),
        .rd_target (t_tgt)
    );

    assign pred_taken = fetch_valid && f_ctr[1];

    gbp_ctl #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_valid (fetch_valid),
        .fetch_idx   (f_idx),
        .dir_taken   (pred_taken),
        .tgt_hit     (t_hit),
        .upd_valid   (upd_valid),
        .pht_en      (pht_en),
        .btb_en      (btb_en),
        .pht_cnt     (pht_cnt),
        .btb_cnt     (btb_cnt)
    );

    assign pred_target = (pred_taken && t_hit) ? t_tgt : fetch_pc + INSN_BYTES;

endmodule

// File: rtl/gbp_chk.sv
module gbp_chk #(
    parameter int PC_W  = 16,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_valid,
    input logic [PC_W-1:0]  fetch_pc,
    input logic             upd_valid,
    input logic             pred_taken,
    input logic [PC_W-1:0]  pred_target,
    input logic             pht_en,
    input logic             btb_en,
    input logic [CNT_W-1:0] pht_cnt,
    input logic [CNT_W-1:0] btb_cnt
);
    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> (!pht_en && !btb_en && !pred_taken));

    // R10
    taken_reads_btb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> btb_en);

    // R5
    update_forces_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (!fetch_valid || pht_en));

    // R8
    fallthrough_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !pred_taken) |-> (pred_target == fetch_pc + PC_W'(4)));

    // R9
    pht_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pht_cnt == $past(pht_cnt) + CNT_W'($past(pht_en))));

    // R9
    btb_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (btb_cnt == $past(btb_cnt) + CNT_W'($past(btb_en))));

endmodule

bind gshare_gated_bp gbp_chk #(.PC_W(PC_W), .CNT_W(CNT_W)) u_gbp_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .upd_valid   (upd_valid),
    .pred_taken  (pred_taken),
    .pred_target (pred_target),
    .pht_en      (pht_en),
    .btb_en      (btb_en),
    .pht_cnt     (pht_cnt),
    .btb_cnt     (btb_cnt)
);

// File: tb/gshare_gated_bp_bench.sv
module gshare_gated_bp_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fetch_valid;
    logic [15:0] fetch_pc;
    logic        upd_valid;
    logic [15:0] upd_pc;
    logic        upd_taken;
    logic [15:0] upd_target;
    logic        pred_taken;
    logic [15:0] pred_target;
    logic        pht_en, btb_en;
    logic [31:0] pht_cnt, btb_cnt;

    always #5 clk = ~clk;

    gshare_gated_bp u_gshare_gated_bp (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target),
        .pred_taken(pred_taken), .pred_target(pred_target),
        .pht_en(pht_en), .btb_en(btb_en), .pht_cnt(pht_cnt), .btb_cnt(btb_cnt)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model, reads both tables every cycle
    int          m_ctr [64];
    logic        m_bv  [16];
    logic [9:0]  m_btag[16];
    logic [15:0] m_btgt[16];
    logic [5:0]  m_ghr;
    logic        m_held_v, m_prev_br;
    logic [4:0]  m_held_row;
    int          m_pcnt, m_bcnt;
    logic        e_taken, e_pht_en, e_btb_en, e_hit;
    logic [15:0] e_target;

    task automatic model_reset();
        for (int i = 0; i < 64; i++) m_ctr[i] = 1;
        for (int i = 0; i < 16; i++) begin m_bv[i] = 0; m_btag[i] = '0; m_btgt[i] = '0; end
        m_ghr = '0; m_held_v = 0; m_held_row = '0; m_prev_br = 0; m_pcnt = 0; m_bcnt = 0;
    endtask

    task automatic model_eval();
        logic [5:0] idx;
        logic [3:0] bi;
        logic       rowhit, ref_hit;
        idx      = fetch_pc[7:2] ^ m_ghr;
        rowhit   = m_held_v && (m_held_row == idx[5:1]);
        e_pht_en = fetch_valid && !rowhit;
        e_taken  = fetch_valid && (m_ctr[idx] >= 2);
        e_btb_en = fetch_valid && (!(rowhit && !m_prev_br) || e_taken);
        bi       = fetch_pc[5:2];
        ref_hit  = m_bv[bi] && (m_btag[bi] == fetch_pc[15:6]);
        e_hit    = e_btb_en && ref_hit;
        e_target = (e_taken && ref_hit) ? m_btgt[bi] : fetch_pc + 16'd4;
    endtask

    task automatic model_commit();
        logic [5:0] ui;
        if (upd_valid) m_held_v = 0;
        else if (e_pht_en) begin m_held_v = 1; m_held_row = (fetch_pc[7:2] ^ m_ghr) >> 1; end
        if (fetch_valid) m_prev_br = e_taken || e_hit;
        m_pcnt += int'(e_pht_en);
        m_bcnt += int'(e_btb_en);
        if (upd_valid) begin
            ui = upd_pc[7:2] ^ m_ghr;
            if (upd_taken && m_ctr[ui] < 3) m_ctr[ui]++;
            if (!upd_taken && m_ctr[ui] > 0) m_ctr[ui]--;
            m_ghr = {m_ghr[4:0], upd_taken};
            if (upd_taken) begin
                m_bv[upd_pc[5:2]] = 1; m_btag[upd_pc[5:2]] = upd_pc[15:6]; m_btgt[upd_pc[5:2]] = upd_target;
            end
        end
    endtask

    // drive at negedge, compare combinational outputs before the rising edge
    task automatic drive_eval(input logic fv, input logic [15:0] pc, input logic uv,
                              input logic [15:0] upc, input logic ut, input logic [15:0] utg);
        @(negedge clk);
        fetch_valid = fv; fetch_pc = pc; upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utg;
        #2;
        model_eval();
        chk(pred_taken == e_taken, "R10/R1 taken", 32'(pred_taken), 32'(e_taken));
        chk(pred_target == e_target, "R10/R8 target", 32'(pred_target), 32'(e_target));
        chk(pht_en == e_pht_en, "R4/R5 pht_en", 32'(pht_en), 32'(e_pht_en));
        chk(btb_en == e_btb_en, "R6/R7 btb_en", 32'(btb_en), 32'(e_btb_en));
    endtask

    task automatic commit();
        @(posedge clk);
        model_commit();
        #1;
        chk(pht_cnt == 32'(m_pcnt), "R9 pht_cnt", pht_cnt, 32'(m_pcnt));
        chk(btb_cnt == 32'(m_bcnt), "R9 btb_cnt", btb_cnt, 32'(m_bcnt));
    endtask

    task automatic step(input logic fv, input logic [15:0] pc, input logic uv,
                        input logic [15:0] upc, input logic ut, input logic [15:0] utg);
        drive_eval(fv, pc, uv, upc, ut, utg);
        commit();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; fetch_valid = 0; fetch_pc = '0; upd_valid = 0; upd_pc = '0; upd_taken = 0; upd_target = '0;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1;
    endtask

    typedef struct packed {
        logic        fv;
        logic [15:0] pc;
        logic        uv;
        logic [15:0] upc;
        logic        ut;
        logic [15:0] utg;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 16'h0100, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{1'b1, 16'h0104, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{1'b1, 16'h0108, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{1'b1, 16'h010c, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{1'b1, 16'h0110, 1'b1, 16'h010c, 1'b1, 16'h0180},
        '{1'b1, 16'h0114, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{1'b1, 16'h0118, 1'b1, 16'h010c, 1'b1, 16'h0180},
        '{1'b1, 16'h011c, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{1'b0, 16'h0120, 1'b1, 16'h010c, 1'b1, 16'h0180},
        '{1'b1, 16'h0108, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{1'b1, 16'h010c, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{1'b1, 16'h0180, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{1'b1, 16'h0184, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{1'b1, 16'h0188, 1'b1, 16'h0184, 1'b0, 16'h0000},
        '{1'b1, 16'h018c, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{1'b1, 16'h0190, 1'b1, 16'h0190, 1'b1, 16'h0100},
        '{1'b1, 16'h0190, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{1'b1, 16'h0194, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{1'b1, 16'h0100, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{1'b1, 16'h0104, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{1'b1, 16'h0108, 1'b1, 16'h0108, 1'b0, 16'h0000},
        '{1'b1, 16'h010c, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{1'b1, 16'h0110, 1'b0, 16'h0000, 1'b0, 16'h0000}
    };

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        // reset state: R9 counters zero
        chk(pht_cnt == 0, "R9 reset pht_cnt", pht_cnt, 0);
        chk(btb_cnt == 0, "R9 reset btb_cnt", btb_cnt, 0);

        // R1 reset counter weak not-taken; R4 first read of a row
        drive_eval(1, 16'h0040, 0, 0, 0, 0);
        chk(pred_taken == 0, "R1 reset ctr", 32'(pred_taken), 0);
        chk(pred_target == 16'h0044, "R8 fallthrough", 32'(pred_target), 32'h44);
        chk(pht_en == 1 && btb_en == 1, "R4 first read", {pht_en, btb_en}, 2'b11);
        commit();
        // R6: same row, not branch, not taken -> both gated
        drive_eval(1, 16'h0044, 0, 0, 0, 0);
        chk(pht_en == 0, "R4 pair reuse", 32'(pht_en), 0);
        chk(btb_en == 0, "R6 gated", 32'(btb_en), 0);
        commit();
        // R7 idle
        drive_eval(0, 16'h0048, 0, 0, 0, 0);
        chk({pht_en, btb_en, pred_taken} == 3'b000, "R7 idle", {pht_en, btb_en, pred_taken}, 0);
        commit();

        // training: R2, R3, R5, R8
        do_reset();
        step(0, 0, 1, 16'h0040, 1, 16'h0300);
        drive_eval(1, 16'h0044, 0, 0, 0, 0);
        chk(pred_taken == 1, "R3 history idx 16", 32'(pred_taken), 1);
        chk(pred_target == 16'h0048, "R8 taken miss", 32'(pred_target), 32'h48);
        chk(pht_en == 1, "R5 row cleared", 32'(pht_en), 1);
        commit();
        for (int k = 0; k < 9; k++) step(0, 0, 1, 16'h0040, 1, 16'h0300);
        drive_eval(1, 16'h0040, 0, 0, 0, 0);
        chk(pred_taken == 1, "R2 trained", 32'(pred_taken), 1);
        chk(pred_target == 16'h0300, "R8 taken hit", 32'(pred_target), 32'h300);
        commit();
        // R11: fetch in same cycle as update sees old state
        drive_eval(1, 16'h0040, 1, 16'h0040, 0, 0);
        chk(pred_taken == 1, "R11 pre-update view", 32'(pred_taken), 1);
        commit();
        drive_eval(1, 16'h0044, 0, 0, 0, 0);
        chk(pred_taken == 1, "R2 saturate at 3", 32'(pred_taken), 1);
        commit();

        // table walk against the always-reading reference
        do_reset();
        for (int v = 0; v < NV; v++)
            step(VEC[v].fv, VEC[v].pc, VEC[v].uv, VEC[v].upc, VEC[v].ut, VEC[v].utg);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule